// File: doc/BRIEF.md
# NAND Invalid-Block Table Scanner

This block walks a raw 8-bit NAND flash array once after power-up and records which erase blocks carry a factory defect marker. For every block it reads a single marker byte from the spare area of page 0 and of page 1. The marker sits at column 517, which is offset 5 into the 16-byte spare area, so each read uses the spare-area read command 50h with column 5. A block whose marker differs from FFh on either page is recorded as invalid. Block 0 is guaranteed good by the flash vendor and always reads back as valid.

The block drives the chip enable, command latch, address latch, write strobe, read strobe and write-protect lines itself. It sends one command byte and three address bytes for each page, then waits out the busy period before it pulses the read strobe once. A host pulses `start`, waits for `done`, and then reads one table bit at a time through an index port. Write-protect stays asserted the whole time, so the array cannot be programmed or erased during the scan.

Top module: `nbt_scanner`

## Requirements
- R1: After reset and while no scan runs, `done` is 0, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle` and `nand_ale` are 0, and every table bit reads 0. `nand_wp_n` is 0 at all times.
- R2: Each page read begins with one command cycle. During that cycle `nand_cle`=1, `nand_ale`=0, `nand_ce_n`=0, `nand_io_oe`=1 and `nand_io_o`=50h, and `nand_we_n` gives a single low pulse.
- R3: The command is followed by exactly three address cycles with `nand_ale`=1 and `nand_cle`=0, each strobed by `nand_we_n`. They carry, in this order, the column 5, then row[7:0], then row[15:8], where row = block*32 + page.
- R4: After the third address cycle the block waits a fixed guard time and then waits for `nand_rb` to be 1. `nand_re_n` is never 0 while `nand_rb` is 0.
- R5: Each page gets exactly one `nand_re_n` low pulse. During that pulse `nand_cle`, `nand_ale`, `nand_ce_n` and `nand_io_oe` are 0. The byte on `nand_io_i` is captured before `nand_re_n` rises.
- R6: Pages are read in the order block 0 page 0, block 0 page 1, block 1 page 0, and so on up to the last block's page 1. No page is read twice.
- R7: A block's table bit becomes 1 when the marker read from page 0 or from page 1 is not FFh. It stays 0 when both markers are FFh.
- R8: The table bit for block 0 always reads 0, whatever markers block 0 holds.
- R9: An accepted `start` (one that arrives while idle or done) clears every table bit on that edge and lowers `done`. A `start` that arrives during a scan has no effect. `done` rises after the last block has been recorded and stays high until the next accepted `start`.
- R10: `tbl_bad` shows, without a clock delay, the table bit of the block selected by `tbl_idx`.
- R11: `nand_ce_n` is 0 for the whole scan and 1 while idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (accepted only when idle or done) |
| done | output | 1 | Scan finished, table valid |
| tbl_idx | input | log2(NUM_BLOCKS) | Block index to read from the table |
| tbl_bad | output | 1 | 1 = selected block marked invalid |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, held low |
| nand_io_o | output | 8 | Byte driven onto the flash data bus |
| nand_io_oe | output | 1 | Output enable for `nand_io_o` |
| nand_io_i | input | 8 | Byte read from the flash data bus |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The checker checks the bus on every cycle. It confirms that a write strobe with the command latch high is a clean command cycle, that address strobes never overlap the command latch, and that a read strobe never appears while the flash reports busy or while the block drives the bus. It also checks that block 0 never reads as invalid and that `done` holds until a restart. The bench scenarios are the only way to show the data side: which bytes and row values go out, that pages arrive in strict ascending order, that a non-FFh marker on either page flags exactly the right blocks, that a restart clears the old table, and that a stray `start` during a scan is ignored.

// File: rtl/nbt_pkg.sv
// Package: shared types for the NAND invalid-block scanner.
// Assumes: an 8-bit flash data bus; all users import this package.
package nbt_pkg;

    // Kind of bus transfer requested from the strobe engine
    typedef enum logic [1:0] {
        XFER_CMD,
        XFER_ADDR,
        XFER_READ
    } xfer_kind_t;

    // Strobe engine phases
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } phy_state_t;

    // Scan sequencer states
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_COL,
        SQ_ROWLO,
        SQ_ROWHI,
        SQ_GUARD,
        SQ_WAITRB,
        SQ_READ,
        SQ_EVAL,
        SQ_DONE
    } seq_state_t;

    // Value of an erased (unmarked) flash byte
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nbt_strobe_phy.sv
// Module: nbt_strobe_phy
// Runs one flash bus transfer at a time (command, address or read byte).
// Each transfer is one setup cycle, STROBE_LOW cycles with the strobe low,
// and STROBE_HIGH cycles with the strobe high. It then pulses ack for one
// cycle while back in idle.
// Assumes: req is held until ack and is dropped during the ack cycle.
module nbt_strobe_phy
    import nbt_pkg::*;
#(
    parameter int STROBE_LOW  = 2,
    parameter int STROBE_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  xfer_kind_t kind,
    input  logic [7:0] wbyte,
    output logic       ack,
    output logic [7:0] rbyte,
    input  logic [7:0] io_i,
    output logic [7:0] io_o,
    output logic       io_oe,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n
);

    localparam int CNT_MAX = (STROBE_LOW > STROBE_HIGH) ? STROBE_LOW : STROBE_HIGH;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(STROBE_LOW - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(STROBE_HIGH - 1);

    phy_state_t       st;
    xfer_kind_t       kind_q;
    logic [7:0]       byte_q;
    logic [CNT_W-1:0] cnt;
    logic             active;

    // Phase sequencing, byte capture and ack generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            kind_q <= XFER_CMD;
            byte_q <= 8'h00;
            cnt    <= '0;
            ack    <= 1'b0;
            rbyte  <= 8'h00;
        end else begin
            ack <= 1'b0;
            case (st)
                PH_IDLE: begin
                    if (req) begin
                        kind_q <= kind;
                        byte_q <= wbyte;
                        st     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt <= '0;
                    st  <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt == LOW_LAST) begin
                        if (kind_q == XFER_READ) begin
                            rbyte <= io_i;
                        end
                        cnt <= '0;
                        st  <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == HIGH_LAST) begin
                        st  <= PH_IDLE;
                        ack <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Bus line decode from the registered phase and transfer kind
    always_comb begin
        active = (st != PH_IDLE);
        cle    = active && (kind_q == XFER_CMD);
        ale    = active && (kind_q == XFER_ADDR);
        we_n   = !((st == PH_LOW) && (kind_q != XFER_READ));
        re_n   = !((st == PH_LOW) && (kind_q == XFER_READ));
        io_oe  = active && (kind_q != XFER_READ);
        io_o   = io_oe ? byte_q : 8'h00;
    end

endmodule

// File: rtl/nbt_scan_seq.sv
// Module: nbt_scan_seq
// Walks blocks 0..NUM_BLOCKS-1 and reads pages 0 and 1 of each. For each
// page it sends the spare-read command, the column, the row low byte and
// the row high byte, waits a guard time and then for ready, and reads one
// marker byte. After page 1 it writes the combined verdict for the block.
// Assumes: row = block*PAGES_PER_BLOCK + page fits in 16 bits.
module nbt_scan_seq
    import nbt_pkg::*;
#(
    parameter int         NUM_BLOCKS      = 1024,
    parameter int         PAGES_PER_BLOCK = 32,
    parameter logic [7:0] MARK_COL        = 8'd5,
    parameter logic [7:0] SPARE_CMD       = 8'h50,
    parameter int         BUSY_GUARD      = 4,
    localparam int        BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             nand_rb,
    input  logic             phy_ack,
    input  logic [7:0]       phy_rbyte,
    output logic             phy_req,
    output xfer_kind_t       phy_kind,
    output logic [7:0]       phy_wbyte,
    output logic             ce_n,
    output logic             done,
    output logic             clr,
    output logic             wr_en,
    output logic [BLK_W-1:0] wr_idx,
    output logic             wr_bad
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam int               GCNT_W   = $clog2(BUSY_GUARD + 1);
    localparam logic [GCNT_W-1:0] GUARD_LAST = GCNT_W'(BUSY_GUARD - 1);

    seq_state_t        st;
    logic [BLK_W-1:0]  blk;
    logic              pg;
    logic              bad_acc;
    logic [GCNT_W-1:0] gcnt;
    logic [15:0]       row;
    logic              page_bad;
    logic              idle_like;
    logic              bus_state;

    // Row address and marker verdict of the page in flight
    always_comb begin
        row       = 16'(blk) * 16'(PAGES_PER_BLOCK) + 16'(pg);
        page_bad  = (phy_rbyte != ERASED_BYTE);
        idle_like = (st == SQ_IDLE) || (st == SQ_DONE);
    end

    // Transfer request to the strobe engine, one per bus state
    always_comb begin
        bus_state = 1'b1;
        phy_kind  = XFER_ADDR;
        phy_wbyte = 8'h00;
        case (st)
            SQ_CMD: begin
                phy_kind  = XFER_CMD;
                phy_wbyte = SPARE_CMD;
            end
            SQ_COL:   phy_wbyte = MARK_COL;
            SQ_ROWLO: phy_wbyte = row[7:0];
            SQ_ROWHI: phy_wbyte = row[15:8];
            SQ_READ:  phy_kind  = XFER_READ;
            default:  bus_state = 1'b0;
        endcase
        phy_req = bus_state && !phy_ack;
    end

    // Status, table clear and table write strobes
    always_comb begin
        ce_n   = idle_like;
        done   = (st == SQ_DONE);
        clr    = start && idle_like;
        wr_en  = (st == SQ_EVAL) && pg;
        wr_idx = blk;
        wr_bad = bad_acc || page_bad;
    end

    // Scan state machine with block, page and guard counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            blk     <= '0;
            pg      <= 1'b0;
            bad_acc <= 1'b0;
            gcnt    <= '0;
        end else begin
            case (st)
                SQ_IDLE, SQ_DONE: begin
                    if (start) begin
                        blk     <= '0;
                        pg      <= 1'b0;
                        bad_acc <= 1'b0;
                        st      <= SQ_CMD;
                    end
                end
                SQ_CMD:   if (phy_ack) st <= SQ_COL;
                SQ_COL:   if (phy_ack) st <= SQ_ROWLO;
                SQ_ROWLO: if (phy_ack) st <= SQ_ROWHI;
                SQ_ROWHI: begin
                    if (phy_ack) begin
                        gcnt <= '0;
                        st   <= SQ_GUARD;
                    end
                end
                SQ_GUARD: begin
                    if (gcnt == GUARD_LAST) begin
                        st <= SQ_WAITRB;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                SQ_WAITRB: if (nand_rb) st <= SQ_READ;
                SQ_READ:   if (phy_ack) st <= SQ_EVAL;
                SQ_EVAL: begin
                    if (!pg) begin
                        bad_acc <= page_bad;
                        pg      <= 1'b1;
                        st      <= SQ_CMD;
                    end else if (blk == LAST_BLK) begin
                        st <= SQ_DONE;
                    end else begin
                        blk     <= blk + 1'b1;
                        pg      <= 1'b0;
                        bad_acc <= 1'b0;
                        st      <= SQ_CMD;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nbt_bad_table.sv
// Module: nbt_bad_table
// One flag per block, cleared all at once by clr and set per block by the
// sequencer. Entry 0 and entries past NUM_BLOCKS are tied to 0 (block 0 is
// guaranteed valid). The read port is combinational.
// Assumes: clr and wr_en are never high in the same cycle.
module nbt_bad_table #(
    parameter int  NUM_BLOCKS = 1024,
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int TBL_N      = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad
);

    logic flags [TBL_N];

    for (genvar b = 0; b < TBL_N; b++) begin : g_entry
        if (b == 0 || b >= NUM_BLOCKS) begin : g_tied
            assign flags[b] = 1'b0;
        end else begin : g_flop
            logic q;
            // Per-block flag: cleared by reset or clr, loaded by its write
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    q <= 1'b0;
                end else if (wr_en && (wr_idx == BLK_W'(b))) begin
                    q <= wr_bad;
                end
            end
            assign flags[b] = q;
        end
    end

    assign rd_bad = flags[rd_idx];

endmodule

// File: rtl/nbt_scanner.sv
// Module: nbt_scanner (top)
// Power-up scan of a raw 8-bit NAND array for factory invalid-block markers.
// Ties the sequencer, the strobe engine and the result table together and
// holds write-protect asserted.
// Assumes: the spare marker byte sits at MARK_BYTE, past PAGE_MAIN main bytes.
module nbt_scanner #(
    parameter int         NUM_BLOCKS      = 1024,
    parameter int         PAGES_PER_BLOCK = 32,
    parameter int         PAGE_MAIN       = 512,
    parameter int         MARK_BYTE       = 517,
    parameter logic [7:0] SPARE_CMD       = 8'h50,
    parameter int         STROBE_LOW      = 2,
    parameter int         STROBE_HIGH     = 2,
    parameter int         BUSY_GUARD      = 4,
    localparam int        BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    input  logic [BLK_W-1:0] tbl_idx,
    output logic             tbl_bad,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_wp_n,
    output logic [7:0]       nand_io_o,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_i,
    input  logic             nand_rb
);

    import nbt_pkg::*;

    localparam logic [7:0] MARK_COL = 8'(MARK_BYTE - PAGE_MAIN);

    logic             phy_req;
    xfer_kind_t       phy_kind;
    logic [7:0]       phy_wbyte;
    logic             phy_ack;
    logic [7:0]       phy_rbyte;
    logic             tbl_clr;
    logic             tbl_wr_en;
    logic [BLK_W-1:0] tbl_wr_idx;
    logic             tbl_wr_bad;

    assign nand_wp_n = 1'b0;

    nbt_scan_seq #(
        .NUM_BLOCKS     (NUM_BLOCKS),
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .MARK_COL       (MARK_COL),
        .SPARE_CMD      (SPARE_CMD),
        .BUSY_GUARD     (BUSY_GUARD)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nand_rb  (nand_rb),
        .phy_ack  (phy_ack),
        .phy_rbyte(phy_rbyte),
        .phy_req  (phy_req),
        .phy_kind (phy_kind),
        .phy_wbyte(phy_wbyte),
        .ce_n     (nand_ce_n),
        .done     (done),
        .clr      (tbl_clr),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_bad   (tbl_wr_bad)
    );

    nbt_strobe_phy #(
        .STROBE_LOW (STROBE_LOW),
        .STROBE_HIGH(STROBE_HIGH)
    ) u_phy (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (phy_req),
        .kind (phy_kind),
        .wbyte(phy_wbyte),
        .ack  (phy_ack),
        .rbyte(phy_rbyte),
        .io_i (nand_io_i),
        .io_o (nand_io_o),
        .io_oe(nand_io_oe),
        .cle  (nand_cle),
        .ale  (nand_ale),
        .we_n (nand_we_n),
        .re_n (nand_re_n)
    );

    nbt_bad_table #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tbl_clr),
        .wr_en (tbl_wr_en),
        .wr_idx(tbl_wr_idx),
        .wr_bad(tbl_wr_bad),
        .rd_idx(tbl_idx),
        .rd_bad(tbl_bad)
    );

endmodule

// File: rtl/nbt_scanner_chk.sv
// Module: nbt_scanner_chk
// Port-level protocol checks for nbt_scanner, bound into every instance.
// Assumes: synchronous active-low reset; all checks are off while in reset.
module nbt_scanner_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [IDX_W-1:0] tbl_idx,
    input logic             tbl_bad,
    input logic             nand_ce_n,
    input logic             nand_cle,
    input logic             nand_ale,
    input logic             nand_we_n,
    input logic             nand_re_n,
    input logic             nand_io_oe,
    input logic             nand_rb
);

    // R2: a write strobe with the command latch high is a full command cycle
    p_cmd_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && nand_cle) |-> (!nand_ale && !nand_ce_n && nand_io_oe));

    // R3: an address strobe never overlaps the command latch
    p_addr_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && nand_ale) |-> (!nand_cle && !nand_ce_n && nand_io_oe));

    // R4: no read strobe while the flash reports busy
    p_no_read_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_rb |-> nand_re_n);

    // R5: a read strobe has both latches low, chip enabled and the bus released
    p_read_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_cle && !nand_ale && !nand_ce_n && !nand_io_oe && nand_we_n));

    // R8: block 0 never reads back as invalid
    p_blk0_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_idx == '0) |-> !tbl_bad);

    // R9: done holds until a start arrives, and an accepted start lowers it
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R11: chip enable is released once the scan is done
    p_ce_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nand_ce_n);

endmodule

bind nbt_scanner nbt_scanner_chk #(.IDX_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .tbl_idx   (tbl_idx),
    .tbl_bad   (tbl_bad),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_io_oe(nand_io_oe),
    .nand_rb   (nand_rb)
);

// File: tb/sim_nbt_scanner.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a behavioural flash model.
module sim_nbt_scanner;

    localparam int NB   = 64;
    localparam int PPB  = 32;
    localparam int IW   = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic [IW-1:0] tbl_idx = '0;
    logic          tbl_bad;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic [7:0]    nand_io_o;
    logic          nand_io_oe;
    logic [7:0]    nand_io_i;
    logic          nand_rb;

    always #2.5 clk = ~clk;

    nbt_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .tbl_idx(tbl_idx), .tbl_bad(tbl_bad),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_io_o(nand_io_o), .nand_io_oe(nand_io_oe),
        .nand_io_i(nand_io_i), .nand_rb(nand_rb)
    );

    // ---------------- flash model ----------------
    logic [7:0]  m0 [NB];
    logic [7:0]  m1 [NB];
    int          busy_len = 12;
    int          busy_cnt = 0;
    logic        prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0]  col_q = 8'h00;
    logic [15:0] row_q = 16'h0000;
    int          acnt = 0;
    int          reads = 0, err_cmd = 0, err_addr = 0, err_busy = 0, err_order = 0;
    int          exp_row = 0;

    assign nand_rb = (busy_cnt == 0);

    // Marker byte for the currently latched address
    always_comb begin
        int b;
        int p;
        b = int'(row_q) / PPB;
        p = int'(row_q) % PPB;
        nand_io_i = 8'h00;
        if (col_q == 8'd5 && b < NB) begin
            if (p == 0)      nand_io_i = m0[b];
            else if (p == 1) nand_io_i = m1[b];
            else             nand_io_i = 8'hFF;
        end
    end

    // Protocol tracking on strobe edges
    always @(posedge clk) begin
        prev_we <= nand_we_n;
        prev_re <= nand_re_n;
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (!prev_we && nand_we_n) begin
            if (nand_cle) begin
                if (nand_io_o != 8'h50 || nand_ale) err_cmd <= err_cmd + 1;
                acnt <= 0;
            end else if (nand_ale) begin
                case (acnt)
                    0: col_q <= nand_io_o;
                    1: row_q[7:0] <= nand_io_o;
                    2: begin
                        row_q[15:8] <= nand_io_o;
                        busy_cnt    <= busy_len;
                    end
                    default: err_addr <= err_addr + 1;
                endcase
                acnt <= acnt + 1;
            end
        end
        if (!nand_re_n && !nand_rb) err_busy <= err_busy + 1;
        if (!prev_re && nand_re_n) begin
            reads <= reads + 1;
            if (acnt != 3 || col_q != 8'd5) err_addr <= err_addr + 1;
            if (int'(row_q) != exp_row) err_order <= err_order + 1;
            if ((exp_row % PPB) == 0) exp_row <= exp_row + 1;
            else exp_row <= exp_row - 1 + PPB;
            acnt <= 4;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bad(input int b);
        return (b != 0) && (m0[b] != 8'hFF || m1[b] != 8'hFF);
    endfunction

    task automatic clear_marks();
        for (int b = 0; b < NB; b++) begin
            m0[b] = 8'hFF;
            m1[b] = 8'hFF;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Reset model counters, start a scan and wait for done
    task automatic run_scan(input string tag);
        int waited;
        @(negedge clk);
        reads = 0; err_cmd = 0; err_addr = 0; err_busy = 0; err_order = 0;
        exp_row = 0;
        pulse_start();
        waited = 0;
        while (!done && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, {tag, " R9 done"}, int'(done), 1);
    endtask

    // Check protocol counters and the full table after a scan
    task automatic check_scan(input string tag);
        chk(reads == 2 * NB, {tag, " R5/R6 page reads"}, reads, 2 * NB);
        chk(err_cmd == 0, {tag, " R2 command cycles"}, err_cmd, 0);
        chk(err_addr == 0, {tag, " R3 address cycles"}, err_addr, 0);
        chk(err_busy == 0, {tag, " R4 read while busy"}, err_busy, 0);
        chk(err_order == 0, {tag, " R6 page order"}, err_order, 0);
        chk(nand_ce_n == 1'b1, {tag, " R11 ce released"}, int'(nand_ce_n), 1);
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            tbl_idx = IW'(b);
            #0.5;
            chk(tbl_bad == exp_bad(b), {tag, " R7/R8/R10 table bit"}, int'(tbl_bad), int'(exp_bad(b)));
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done idle", int'(done), 0);
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1/R11 strobes idle",
            int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
        chk(!nand_cle && !nand_ale, "R1 latches idle", int'({nand_cle, nand_ale}), 0);
        chk(nand_wp_n == 1'b0, "R1 write protect", int'(nand_wp_n), 0);
        for (int b = 0; b < NB; b += 9) begin
            tbl_idx = IW'(b);
            #0.5;
            chk(tbl_bad == 1'b0, "R1 table cleared", int'(tbl_bad), 0);
        end
    endtask

    task automatic t_clean();
        int ce_mid;
        int wp_mid;
        clear_marks();
        busy_len = 12;
        @(negedge clk);
        reads = 0; err_cmd = 0; err_addr = 0; err_busy = 0; err_order = 0;
        exp_row = 0;
        pulse_start();
        repeat (200) @(negedge clk);
        ce_mid = int'(nand_ce_n);
        wp_mid = int'(nand_wp_n);
        chk(ce_mid == 0, "R11 ce low during scan", ce_mid, 0);
        chk(wp_mid == 0, "R1 write protect during scan", wp_mid, 0);
        chk(done == 1'b0, "R9 done low during scan", int'(done), 0);
        while (!done) @(negedge clk);
        check_scan("clean");
    endtask

    task automatic t_page0_marks();
        clear_marks();
        m0[3] = 8'h00;
        m0[17] = 8'hFE;
        m0[40] = 8'h7F;
        run_scan("page0");
        check_scan("page0");
    endtask

    task automatic t_page1_marks();
        clear_marks();
        m1[5] = 8'h00;
        m1[22] = 8'hEF;
        m0[30] = 8'h01;
        m1[30] = 8'h01;
        run_scan("page1");
        check_scan("page1");
    endtask

    task automatic t_block0_last();
        clear_marks();
        m0[0] = 8'h00;
        m1[0] = 8'h00;
        m1[NB-1] = 8'h3C;
        m0[1] = 8'hFF;
        run_scan("edges");
        check_scan("edges");
        @(negedge clk);
        tbl_idx = '0;
        #0.5;
        chk(tbl_bad == 1'b0, "R8 block 0 valid", int'(tbl_bad), 0);
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R9 done holds", int'(done), 1);
    endtask

    task automatic t_long_busy();
        clear_marks();
        m0[9] = 8'h00;
        busy_len = 60;
        run_scan("busy");
        check_scan("busy");
        busy_len = 12;
    endtask

    task automatic t_restart_ignored();
        clear_marks();
        m1[12] = 8'h00;
        @(negedge clk);
        reads = 0; err_cmd = 0; err_addr = 0; err_busy = 0; err_order = 0;
        exp_row = 0;
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        while (!done) @(negedge clk);
        check_scan("restart");
    endtask

    task automatic t_rescan_clears();
        clear_marks();
        m0[7] = 8'h00;
        run_scan("pre");
        clear_marks();
        @(negedge clk);
        reads = 0; err_cmd = 0; err_addr = 0; err_busy = 0; err_order = 0;
        exp_row = 0;
        tbl_idx = IW'(7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #0.5;
        chk(tbl_bad == 1'b0, "R9 start clears table", int'(tbl_bad), 0);
        chk(done == 1'b0, "R9 start lowers done", int'(done), 0);
        while (!done) @(negedge clk);
        check_scan("rescan");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clear_marks();
        t_reset();
        t_clean();
        t_page0_marks();
        t_page1_marks();
        t_block0_last();
        t_long_busy();
        t_restart_ignored();
        t_rescan_clears();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule